// File: doc/BRIEF.md
# SPI Command Frame Decoder

This block is the serial front end of a four-channel wiper controller. It receives SPI frames on SI, checks that each frame is addressed to this device, and turns the frame into one decoded command. That command is presented to the register storage as a one-cycle strobe in the system clock domain. It also returns read data on SO. The register storage and the timing of nonvolatile writes are handled by other blocks.

SCK, chip select, SI and the pause input are oversampled by the system clock through synchronizer stages, and all frame logic runs in the system clock domain. The first byte of a frame carries a device-type nibble and a four-bit slave address, of which the two low bits are set by strap pins. The second byte packs an opcode, a data-register pointer and a channel pointer. Write-type opcodes take a third byte as data. No-data and read opcodes issue their command as soon as the second byte ends. For a read opcode, the register storage returns a byte that the block shifts out on SO. The pause input can stop the frame part-way through and resume it later without losing position. Each SCK half-period must last at least six system clock cycles.

Top module: `spi_cmd_frontend`

## Requirements
- R1: SI is captured on SCK rising edges, most significant bit first. Bytes are counted from the chip-select falling edge that opens the frame.
- R2: The first byte is accepted only when bits [7:4] equal 4'b0101, bits [3:2] are 2'b00 and bits [1:0] equal `addr_strap`. On any other first byte, the rest of the frame issues no command and does not drive SO.
- R3: In the second byte, bits [7:4] form `cmd_op`, bits [3:2] form `cmd_dreg` and bits [1:0] form `cmd_chan`.
- R4: For an opcode that is neither read nor no-data, the third byte is the data byte. It issues one command with `cmd_wdata` equal to that byte. Any later bytes in the frame are ignored.
- R5: The no-data opcodes are 4'h1, 4'h2, 4'h8 and 4'hD. Each issues its command at the end of the second byte, with `cmd_wdata` = 8'h00.
- R6: The read opcodes are 4'h9 and 4'hB. Each issues its command at the end of the second byte, and `rd_data` is captured in the strobe cycle. That byte is driven on SO, MSB first, with a new bit after each SCK falling edge. The first bit follows the falling edge that closes the second byte.
- R7: While chip select is high, `spi_so_oe` is low and the frame state returns to idle.
- R8: After reset, chip select must be seen high and then fall before any frame is accepted. A frame clocked while chip select has stayed low since reset issues nothing.
- R9: When `spi_hold_n` goes low while SCK is low, the frame pauses. It resumes when `spi_hold_n` goes high while SCK is low. While paused, SCK edges are ignored, the bit position is kept, and `spi_so_oe` is low.
- R10: If chip select rises before a command's last byte is complete, the frame is aborted and no command is issued.
- R11: `cmd_valid` is high for exactly one clock per accepted command. The command fields hold their values until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low frame pause |
| addr_strap | input | 2 | Strapped low bits of the slave address |
| rd_data | input | 8 | Read byte from the register storage, valid during a read strobe |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for SO (low = high impedance) |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Decoded opcode |
| cmd_dreg | output | 2 | Data-register pointer |
| cmd_chan | output | 2 | Channel pointer |
| cmd_wdata | output | 8 | Data byte for write-type commands |

## Verification
If the bit counter slips or freezes, the command fields show up shifted or the strobe is missing when chip select rises after the frame. This is visible within a few system clocks of the last SCK rising edge. A wrong identification state shows as a strobe on a frame with a foreign address, or as no strobe on a valid one. A pause that does not hold state corrupts the data byte or the SO bits that follow the resume. An output enable that stays high through chip-select release or a pause is visible on `spi_so_oe` one clock later.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  parameter int BYTE_W = 8;
  parameter int OP_W   = 4;
  parameter int PTR_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int NUM_OP = 1 << OP_W;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_ID,
    FS_INSTR,
    FS_DATA,
    FS_SKIP
  } frame_st_e;

  // identification byte: type nibble, two zero bits, strapped pair
  function automatic logic id_match(input logic [BYTE_W-1:0] b,
                                    input logic [OP_W-1:0]   dev_type,
                                    input logic [PTR_W-1:0]  strap);
    return (b[BYTE_W-1 -: OP_W] == dev_type) &&
           (b[2*PTR_W-1 -: PTR_W] == '0) &&
           (b[PTR_W-1:0] == strap);
  endfunction

  function automatic logic [OP_W-1:0] op_of(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: OP_W];
  endfunction

  function automatic logic [PTR_W-1:0] dreg_of(input logic [BYTE_W-1:0] b);
    return b[2*PTR_W-1 -: PTR_W];
  endfunction

  function automatic logic [PTR_W-1:0] chan_of(input logic [BYTE_W-1:0] b);
    return b[PTR_W-1:0];
  endfunction

  function automatic logic op_flag(input logic [NUM_OP-1:0] mask,
                                   input logic [OP_W-1:0]   op);
    return mask[op];
  endfunction

endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
  parameter int            W       = 4,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_pin_cond.sv
module spi_pin_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_hi,
  output logic cs_fall,
  output logic si_s,
  output logic hold_act
);

  localparam int NLINES = 4;
  // chip select resets low so a low line at reset is never seen as a fall
  localparam logic [NLINES-1:0] LINE_RST = 4'b1000;

  logic [NLINES-1:0] lines;
  logic sck_s, cs_n_s, hold_n_s;
  logic sck_prev_q, cs_prev_q, hold_q;

  spi_line_sync #(
    .W      (NLINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({hold_n, si, cs_n, sck}),
    .q    (lines)
  );

  assign sck_s    = lines[0];
  assign cs_n_s   = lines[1];
  assign si_s     = lines[2];
  assign hold_n_s = lines[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      cs_prev_q  <= cs_n_s;
      // pause state only changes while the serial clock is low
      if (!sck_s) hold_q <= !hold_n_s;
    end
  end

  assign sck_rise = sck_s & ~sck_prev_q;
  assign sck_fall = ~sck_s & sck_prev_q;
  assign cs_hi    = cs_n_s;
  assign cs_fall  = cs_prev_q & ~cs_n_s;
  assign hold_act = hold_q;

endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_cmd_pkg::*;
#(
  parameter logic [OP_W-1:0]   DEV_TYPE   = 4'b0101,
  parameter logic [NUM_OP-1:0] RD_OPS     = 16'h0A00,
  parameter logic [NUM_OP-1:0] NODATA_OPS = 16'h2106
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_hi,
  input  logic              cs_fall,
  input  logic              si,
  input  logic              hold_act,
  input  logic [PTR_W-1:0]  strap,
  output logic              armed,
  output logic              id_ok,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [PTR_W-1:0]  cmd_dreg,
  output logic [PTR_W-1:0]  cmd_chan,
  output logic [BYTE_W-1:0] cmd_wdata
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  frame_st_e         state_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] byte_now;
  logic [OP_W-1:0]   ins_op_q;
  logic [PTR_W-1:0]  ins_dreg_q, ins_chan_q;
  logic              shift_en, byte_done, instr_short;

  assign byte_now    = {sh_q[BYTE_W-2:0], si};
  assign shift_en    = sck_rise && !hold_act && (state_q != FS_IDLE);
  assign byte_done   = shift_en && (bit_cnt == LAST_BIT);
  assign instr_short = op_flag(RD_OPS, op_of(byte_now)) ||
                       op_flag(NODATA_OPS, op_of(byte_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      sh_q       <= '0;
      bit_cnt    <= '0;
      armed      <= 1'b0;
      id_ok      <= 1'b0;
      ins_op_q   <= '0;
      ins_dreg_q <= '0;
      ins_chan_q <= '0;
      cmd_valid  <= 1'b0;
      cmd_op     <= '0;
      cmd_dreg   <= '0;
      cmd_chan   <= '0;
      cmd_wdata  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (cs_hi) armed <= 1'b1;

      if (cs_hi) begin
        state_q <= FS_IDLE;
        bit_cnt <= '0;
        id_ok   <= 1'b0;
      end else if (cs_fall && armed) begin
        state_q <= FS_ID;
        bit_cnt <= '0;
      end else if (shift_en) begin
        sh_q    <= byte_now;
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (byte_done) begin
          case (state_q)
            FS_ID: begin
              if (id_match(byte_now, DEV_TYPE, strap)) begin
                id_ok   <= 1'b1;
                state_q <= FS_INSTR;
              end else begin
                state_q <= FS_SKIP;
              end
            end
            FS_INSTR: begin
              ins_op_q   <= op_of(byte_now);
              ins_dreg_q <= dreg_of(byte_now);
              ins_chan_q <= chan_of(byte_now);
              if (instr_short) begin
                cmd_valid <= 1'b1;
                cmd_op    <= op_of(byte_now);
                cmd_dreg  <= dreg_of(byte_now);
                cmd_chan  <= chan_of(byte_now);
                cmd_wdata <= '0;
                state_q   <= FS_SKIP;
              end else begin
                state_q   <= FS_DATA;
              end
            end
            FS_DATA: begin
              cmd_valid <= 1'b1;
              cmd_op    <= ins_op_q;
              cmd_dreg  <= ins_dreg_q;
              cmd_chan  <= ins_chan_q;
              cmd_wdata <= byte_now;
              state_q   <= FS_SKIP;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_so_shift.sv
module spi_so_shift
  import spi_cmd_pkg::*;
#(
  parameter logic [NUM_OP-1:0] RD_OPS = 16'h0A00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              hold_act,
  input  logic              sck_fall,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              so,
  output logic              so_oe
);

  logic [BYTE_W-1:0] sh_q;
  logic              pend_q, drive_q, so_q, oe_q;
  logic              load;

  assign load = cmd_valid && op_flag(RD_OPS, cmd_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      pend_q  <= 1'b0;
      drive_q <= 1'b0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (cs_hi) begin
        sh_q    <= '0;
        pend_q  <= 1'b0;
        drive_q <= 1'b0;
      end else if (load) begin
        sh_q   <= rd_data;
        pend_q <= 1'b1;
      end else if (sck_fall && !hold_act && pend_q) begin
        so_q    <= sh_q[BYTE_W-1];
        sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
        drive_q <= 1'b1;
      end
      oe_q <= drive_q && !hold_act && !cs_hi;
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q;

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_cmd_pkg::*;
#(
  parameter logic [OP_W-1:0]   DEV_TYPE    = 4'b0101,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NUM_OP-1:0] RD_OPS      = 16'h0A00,
  parameter logic [NUM_OP-1:0] NODATA_OPS  = 16'h2106
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  input  logic [PTR_W-1:0]  addr_strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [PTR_W-1:0]  cmd_dreg,
  output logic [PTR_W-1:0]  cmd_chan,
  output logic [BYTE_W-1:0] cmd_wdata
);

  // internal events, named for the bound checker
  logic             sck_rise, sck_fall;
  logic             cs_hi_s, cs_fall;
  logic             si_s, hold_act;
  logic             armed, id_ok;
  logic [CNT_W-1:0] bit_cnt;

  spi_pin_cond #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .si      (spi_si),
    .hold_n  (spi_hold_n),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .cs_hi   (cs_hi_s),
    .cs_fall (cs_fall),
    .si_s    (si_s),
    .hold_act(hold_act)
  );

  spi_frame_ctl #(
    .DEV_TYPE  (DEV_TYPE),
    .RD_OPS    (RD_OPS),
    .NODATA_OPS(NODATA_OPS)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_rise (sck_rise),
    .cs_hi    (cs_hi_s),
    .cs_fall  (cs_fall),
    .si       (si_s),
    .hold_act (hold_act),
    .strap    (addr_strap),
    .armed    (armed),
    .id_ok    (id_ok),
    .bit_cnt  (bit_cnt),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_dreg (cmd_dreg),
    .cmd_chan (cmd_chan),
    .cmd_wdata(cmd_wdata)
  );

  spi_so_shift #(
    .RD_OPS(RD_OPS)
  ) u_so (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_hi    (cs_hi_s),
    .hold_act (hold_act),
    .sck_fall (sck_fall),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .rd_data  (rd_data),
    .so       (spi_so),
    .so_oe    (spi_so_oe)
  );

endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             spi_so_oe,
  input logic             cs_hi_s,
  input logic             hold_act,
  input logic             armed,
  input logic             id_ok,
  input logic [CNT_W-1:0] bit_cnt
);

  // R11
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R7
  cs_release_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi_s |=> !spi_so_oe);

  // R9
  hold_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |=> !spi_so_oe);

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_hi_s) |=> $stable(bit_cnt));

  // R2
  id_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> id_ok);

  // R8
  armed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> armed);

  // R10
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi_s |=> !cmd_valid);

endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk #(.CNT_W(spi_cmd_pkg::CNT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .spi_so_oe(spi_so_oe),
  .cs_hi_s  (cs_hi_s),
  .hold_act (hold_act),
  .armed    (armed),
  .id_ok    (id_ok),
  .bit_cnt  (bit_cnt)
);

// File: tb/test_spi_cmd_frontend.sv
`timescale 1ns/1ps
module test_spi_cmd_frontend;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic [1:0] addr_strap = 2'b10;
  logic [7:0] rd_val = 8'h00;
  logic       spi_so, spi_so_oe, cmd_valid;
  logic [3:0] cmd_op;
  logic [1:0] cmd_dreg, cmd_chan;
  logic [7:0] cmd_wdata;

  int checks = 0, errors = 0, stb_cnt = 0, wide_cnt = 0;
  logic prev_valid = 1'b0;
  logic [3:0] cap_op;
  logic [1:0] cap_dreg, cap_chan;
  logic [7:0] cap_wdata;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_cmd_frontend i_spi_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_hold_n(spi_hold_n), .addr_strap(addr_strap),
    .rd_data(rd_val), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dreg(cmd_dreg),
    .cmd_chan(cmd_chan), .cmd_wdata(cmd_wdata)
  );

  // command monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (cmd_valid) begin
      stb_cnt++;
      cap_op = cmd_op; cap_dreg = cmd_dreg; cap_chan = cmd_chan; cap_wdata = cmd_wdata;
      if (prev_valid) wide_cnt++;
    end
    prev_valid = cmd_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r, output logic oe);
    spi_si = b;
    wait_clk(HALF);
    r = spi_so; oe = spi_so_oe;
    spi_sck = 1'b1;
    wait_clk(HALF);
    spi_sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r, output int oe_cnt);
    oe_cnt = 0;
    for (int i = 7; i >= 0; i--) begin
      logic rb, ob;
      spi_bit(b[i], rb, ob);
      r[i] = rb;
      if (ob) oe_cnt++;
    end
  endtask

  task automatic cs_open();
    spi_cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_close();
    wait_clk(HALF); spi_cs_n = 1'b1; wait_clk(3 * HALF);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r; int o;
    spi_byte(b, r, o);
  endtask

  task automatic t_reset();
    chk(cmd_valid == 1'b0, "R11 reset strobe", cmd_valid, 0);
    chk(spi_so_oe == 1'b0, "R7 reset so_oe", spi_so_oe, 0);
  endtask

  task automatic t_write();
    int s0 = stb_cnt;
    cs_open(); send(8'h52); send(8'hC9); send(8'hA5); send(8'h3F); cs_close();
    chk(stb_cnt - s0 == 1, "R4 one strobe, extra byte ignored", stb_cnt - s0, 1);
    chk(cap_op == 4'hC, "R3 opcode", cap_op, 4'hC);
    chk(cap_dreg == 2'd2, "R3 dreg", cap_dreg, 2);
    chk(cap_chan == 2'd1, "R3 chan", cap_chan, 1);
    chk(cap_wdata == 8'hA5, "R1 R4 data byte", cap_wdata, 8'hA5);
    chk(cmd_op == 4'hC && cmd_wdata == 8'hA5, "R11 fields held", cmd_wdata, 8'hA5);
  endtask

  task automatic t_bad_id(input logic [7:0] id, input string tag);
    int s0 = stb_cnt; logic [7:0] r; int o;
    cs_open(); send(id); send(8'h92); spi_byte(8'h00, r, o); cs_close();
    chk(stb_cnt == s0, tag, stb_cnt - s0, 0);
    chk(o == 0, "R2 no SO drive on foreign frame", o, 0);
  endtask

  task automatic t_nodata();
    int s0 = stb_cnt;
    cs_open(); send(8'h52); send(8'h17); cs_close();
    chk(stb_cnt - s0 == 1, "R5 strobe after instruction", stb_cnt - s0, 1);
    chk(cap_op == 4'h1 && cap_dreg == 2'd1 && cap_chan == 2'd3, "R5 fields",
        {cap_op, cap_dreg, cap_chan}, 8'h17);
    chk(cap_wdata == 8'h00, "R5 zero data", cap_wdata, 0);
  endtask

  task automatic t_read();
    int s0 = stb_cnt; logic [7:0] r; int o;
    rd_val = 8'h3C;
    cs_open(); send(8'h52); send(8'hB6);
    spi_byte(8'h00, r, o);
    chk(stb_cnt - s0 == 1 && cap_op == 4'hB, "R6 read strobe", cap_op, 4'hB);
    chk(r == 8'h3C, "R6 SO byte", r, 8'h3C);
    chk(o == 8, "R6 SO driven", o, 8);
    cs_close();
    chk(spi_so_oe == 1'b0, "R7 SO released", spi_so_oe, 0);
  endtask

  task automatic t_abort();
    int s0 = stb_cnt;
    cs_open(); send(8'h52); send(8'hC9);
    for (int i = 0; i < 4; i++) begin
      logic rb, ob;
      spi_bit(1'b1, rb, ob);
    end
    cs_close();
    chk(stb_cnt == s0, "R10 aborted frame", stb_cnt - s0, 0);
  endtask

  task automatic hold_pause(output logic oe_seen);
    spi_hold_n = 1'b0; wait_clk(HALF);
    oe_seen = spi_so_oe;
    for (int k = 0; k < 3; k++) begin
      spi_si = k[0]; spi_sck = 1'b1; wait_clk(HALF); spi_sck = 1'b0; wait_clk(HALF);
    end
    spi_hold_n = 1'b1; wait_clk(HALF);
  endtask

  task automatic t_hold_write();
    int s0 = stb_cnt; logic [7:0] d = 8'h6B; logic oe;
    cs_open(); send(8'h52); send(8'hE4);
    for (int i = 7; i >= 0; i--) begin
      logic rb, ob;
      if (i == 4) hold_pause(oe);
      spi_bit(d[i], rb, ob);
    end
    cs_close();
    chk(stb_cnt - s0 == 1, "R9 one strobe across pause", stb_cnt - s0, 1);
    chk(cap_wdata == 8'h6B, "R9 data across pause", cap_wdata, 8'h6B);
  endtask

  task automatic t_hold_read();
    logic [7:0] r; logic oe;
    rd_val = 8'hD2;
    cs_open(); send(8'h52); send(8'h9F);
    for (int i = 7; i >= 0; i--) begin
      logic rb, ob;
      if (i == 4) hold_pause(oe);
      spi_bit(1'b0, rb, ob);
      r[i] = rb;
    end
    cs_close();
    chk(oe == 1'b0, "R9 SO off while paused", oe, 0);
    chk(r == 8'hD2, "R9 R6 read across pause", r, 8'hD2);
  endtask

  task automatic t_powerup();
    int s0;
    rst_n = 1'b0; spi_cs_n = 1'b0; wait_clk(10); rst_n = 1'b1; wait_clk(10);
    s0 = stb_cnt;
    send(8'h52); send(8'h17); wait_clk(HALF);
    chk(stb_cnt == s0, "R8 no frame without chip-select fall", stb_cnt - s0, 0);
    spi_cs_n = 1'b1; wait_clk(3 * HALF);
    cs_open(); send(8'h52); send(8'h28); cs_close();
    chk(stb_cnt - s0 == 1 && cap_op == 4'h2, "R8 frame after chip-select fall", cap_op, 2);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    t_reset();
    t_write();
    t_bad_id(8'h51, "R2 strap mismatch");
    t_bad_id(8'h56, "R2 nonzero bits 3:2");
    t_bad_id(8'h62, "R2 wrong device type");
    t_nodata();
    t_read();
    t_abort();
    t_hold_write();
    t_hold_read();
    t_powerup();
    chk(wide_cnt == 0, "R11 strobe width", wide_cnt, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule